// File: doc/BRIEF.md
# Memory Tag Load Execution Unit

This unit carries out one "load allocation tag" operation for a 64-bit load/store pipeline. It takes a 32-bit instruction word on a start pulse and checks that the word has the right encoding and that the tag feature is on. It reads the base and destination registers through a combinational register-file read port. The base is either a general register or the stack pointer. The unit adds a signed immediate, scaled to whole 16-byte granules, to the base and clears the low four bits of the sum. It then fetches the 4-bit tag for that granule from a tag memory, using a request/valid handshake.

When the tag arrives, the unit puts it into the tag field of the destination register's old value and offers the result on a writeback port. The result is qualified by a single-cycle done pulse. An invalid encoding, or a disabled feature, ends the operation with an undefined-instruction flag. A misaligned stack pointer ends it with an alignment fault. In both cases no memory request and no writeback happen. The unit holds one operation at a time and shows busy while it runs.

Top module: `tagld_unit`

## Requirements
- R1: The word is accepted only when bits [31:24] = 8'hD9, bits [23:22] = 2'b01, bit 21 = 1 and bits [11:10] = 2'b00. The fields are imm9 = [20:12], base index = [9:5] and destination index = [4:0]. Any other word ends with undef_o high, no tmem_req_o and no wb_en_o.
- R2: With feat_en_i low, even a correctly encoded word ends with undef_o high, no memory request and no writeback.
- R3: The address is base + (sign-extended imm9 × 16), with its low 4 bits cleared. tmem_addr_o carries address bits [AW+3:4] during the request cycle.
- R4: A base index of 31 selects sp_i. If sp_i[3:0] is nonzero, the operation ends with spfault_o high, no memory request and no writeback. Any other index reads the register file.
- R5: The writeback value is the destination register's old value with bits [59:56] replaced by the 4-bit tag. Every other bit is kept.
- R6: A destination index of 31 is the zero register. The operation completes with done_o and no flags, and wb_en_o stays low.
- R7: Each accepted operation raises tmem_req_o for exactly one cycle. The unit waits any number of cycles for tmem_vld_i. A tmem_vld_i outside that wait is ignored.
- R8: done_o is a one-cycle pulse. For undef or fault it comes two cycles after the start is sampled. Otherwise it comes in the cycle after tmem_vld_i is sampled, and wb_addr_o and wb_data_o are valid with it.
- R9: busy_o is high from the cycle after start is accepted through the done cycle. A start_i seen while busy_o is high is ignored.
- R10: After reset, busy_o, done_o, tmem_req_o, wb_en_o, undef_o and spfault_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Accept an instruction when idle |
| insn_i | input | 32 | Instruction word |
| feat_en_i | input | 1 | Tag feature enable |
| sp_i | input | 64 | Stack pointer value |
| rf_addr_a_o | output | 5 | Base register read index |
| rf_data_a_i | input | 64 | Base register read data |
| rf_addr_b_o | output | 5 | Destination register read index |
| rf_data_b_i | input | 64 | Destination register read data |
| tmem_req_o | output | 1 | Tag read request |
| tmem_addr_o | output | AW | Granule index of the tag read |
| tmem_vld_i | input | 1 | Tag read answer valid |
| tmem_tag_i | input | 4 | Tag read data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Completion pulse |
| undef_o | output | 1 | Undefined-instruction status with done |
| spfault_o | output | 1 | Stack pointer alignment fault with done |
| wb_en_o | output | 1 | Register write enable with done |
| wb_addr_o | output | 5 | Register write index |
| wb_data_o | output | 64 | Register write data |

## Verification
The hardest case to reach is a tag answer, or a new start, that arrives at a moment when the unit must not take it. Examples are a valid pulse during the decode cycle, or a second start with a different word while a read is still pending. The bench drives a stray tmem_vld_i in the decode cycle and a conflicting start_i in the request cycle, and it holds the real answer back for several cycles. It then checks that the result still matches the first word. Address wrap-around below zero and the far ends of the immediate range are also driven on purpose.

// File: rtl/tagld_pkg.sv
package tagld_pkg;
  localparam int XLEN      = 64;
  localparam int GRAN_LOG2 = 4;
  localparam int TAG_W     = 4;
  localparam int TAG_LSB   = 56;
  localparam int IMM_W     = 9;
  localparam logic [4:0] REG_ZR = 5'd31;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEC, ST_REQ, ST_WAIT, ST_RESP
  } st_e;

  typedef struct packed {
    logic             hit;
    logic [IMM_W-1:0] imm;
    logic [4:0]       rn;
    logic [4:0]       rt;
  } dec_t;
endpackage

// File: rtl/tagld_decode.sv
module tagld_decode
  import tagld_pkg::*;
(
  input  logic [31:0] insn,
  output dec_t        dec
);
  logic top_ok, opc_ok, b21_ok, op2_ok;

  always_comb begin
    top_ok  = (insn[31:24] == 8'hD9);
    opc_ok  = (insn[23:22] == 2'b01);
    b21_ok  = insn[21];
    op2_ok  = (insn[11:10] == 2'b00);
    dec.hit = top_ok & opc_ok & b21_ok & op2_ok;
    dec.imm = insn[20:12];
    dec.rn  = insn[9:5];
    dec.rt  = insn[4:0];
  end
endmodule

// File: rtl/tagld_agen.sv
module tagld_agen
  import tagld_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [4:0]       rn,
  input  logic [IMM_W-1:0] imm,
  input  logic [XLEN-1:0]  sp,
  input  logic [XLEN-1:0]  xn,
  output logic [AW-1:0]    gidx,
  output logic             sp_misal
);
  localparam int EXT_W = XLEN - IMM_W;

  logic            use_sp;
  logic [XLEN-1:0] base, offs, sum;

  always_comb begin
    use_sp   = (rn == REG_ZR);
    base     = use_sp ? sp : xn;
    offs     = {{EXT_W{imm[IMM_W-1]}}, imm} << GRAN_LOG2;
    sum      = base + offs;
    gidx     = sum[AW+GRAN_LOG2-1:GRAN_LOG2];
    sp_misal = use_sp & (|sp[GRAN_LOG2-1:0]);
  end
endmodule

// File: rtl/tagld_merge.sv
module tagld_merge
  import tagld_pkg::*;
(
  input  logic [XLEN-1:0]  old_val,
  input  logic [TAG_W-1:0] tag,
  output logic [XLEN-1:0]  new_val
);
  for (genvar b = 0; b < XLEN; b++) begin : g_bit
    if (b >= TAG_LSB && b < TAG_LSB + TAG_W) begin : g_tag
      assign new_val[b] = tag[b-TAG_LSB];
    end else begin : g_keep
      assign new_val[b] = old_val[b];
    end
  end
endmodule

// File: rtl/tagld_unit.sv
module tagld_unit
  import tagld_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [31:0]      insn_i,
  input  logic             feat_en_i,
  input  logic [XLEN-1:0]  sp_i,
  output logic [4:0]       rf_addr_a_o,
  input  logic [XLEN-1:0]  rf_data_a_i,
  output logic [4:0]       rf_addr_b_o,
  input  logic [XLEN-1:0]  rf_data_b_i,
  output logic             tmem_req_o,
  output logic [AW-1:0]    tmem_addr_o,
  input  logic             tmem_vld_i,
  input  logic [TAG_W-1:0] tmem_tag_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             undef_o,
  output logic             spfault_o,
  output logic             wb_en_o,
  output logic [4:0]       wb_addr_o,
  output logic [XLEN-1:0]  wb_data_o
);
  st_e             st_q, st_d;
  logic [31:0]     insn_q;
  logic [AW-1:0]   gidx_q;
  logic [XLEN-1:0] xt_q, wbd_q, wbd_d;
  logic            done_q, done_d, und_q, und_d, flt_q, flt_d, wbe_q, wbe_d;
  logic            ld_insn, ld_ops, ld_wbd;

  dec_t            dec;
  logic [AW-1:0]   gidx;
  logic            sp_misal;
  logic [XLEN-1:0] merged;

  tagld_decode u_dec (.insn(insn_q), .dec(dec));

  tagld_agen #(.AW(AW)) u_agen (
    .rn(dec.rn), .imm(dec.imm), .sp(sp_i), .xn(rf_data_a_i),
    .gidx(gidx), .sp_misal(sp_misal)
  );

  tagld_merge u_merge (.old_val(xt_q), .tag(tmem_tag_i), .new_val(merged));

  always_comb begin
    st_d    = st_q;
    done_d  = 1'b0;
    und_d   = 1'b0;
    flt_d   = 1'b0;
    wbe_d   = 1'b0;
    wbd_d   = wbd_q;
    ld_insn = 1'b0;
    ld_ops  = 1'b0;
    ld_wbd  = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        ld_insn = 1'b1;
        st_d    = ST_DEC;
      end
      ST_DEC: begin
        if (!(dec.hit && feat_en_i)) begin
          done_d = 1'b1;
          und_d  = 1'b1;
          st_d   = ST_RESP;
        end else if (sp_misal) begin
          done_d = 1'b1;
          flt_d  = 1'b1;
          st_d   = ST_RESP;
        end else begin
          ld_ops = 1'b1;
          st_d   = ST_REQ;
        end
      end
      ST_REQ:  st_d = ST_WAIT;
      ST_WAIT: if (tmem_vld_i) begin
        done_d = 1'b1;
        wbe_d  = (dec.rt != REG_ZR);
        ld_wbd = 1'b1;
        wbd_d  = merged;
        st_d   = ST_RESP;
      end
      ST_RESP: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
      und_q  <= 1'b0;
      flt_q  <= 1'b0;
      wbe_q  <= 1'b0;
      insn_q <= '0;
      gidx_q <= '0;
      xt_q   <= '0;
      wbd_q  <= '0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      und_q  <= und_d;
      flt_q  <= flt_d;
      wbe_q  <= wbe_d;
      if (ld_insn) insn_q <= insn_i;
      if (ld_ops) begin
        gidx_q <= gidx;
        xt_q   <= rf_data_b_i;
      end
      if (ld_wbd) wbd_q <= wbd_d;
    end
  end

  assign rf_addr_a_o = dec.rn;
  assign rf_addr_b_o = dec.rt;
  assign tmem_req_o  = (st_q == ST_REQ);
  assign tmem_addr_o = gidx_q;
  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;
  assign undef_o     = und_q;
  assign spfault_o   = flt_q;
  assign wb_en_o     = wbe_q;
  assign wb_addr_o   = dec.rt;
  assign wb_data_o   = wbd_q;
endmodule

// File: rtl/tagld_chk.sv
module tagld_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       tmem_req_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       undef_o,
  input logic       spfault_o,
  input logic       wb_en_o,
  input logic [4:0] wb_addr_o
);
  a_r7_single_req: assert property (@(posedge clk) disable iff (!rst_n)
    tmem_req_o |=> !tmem_req_o);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r1_undef_excl: assert property (@(posedge clk) disable iff (!rst_n)
    undef_o |-> (!wb_en_o && !spfault_o));
  a_r4_fault_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    spfault_o |-> !wb_en_o);
  a_r8_flags_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en_o || undef_o || spfault_o) |-> done_o);
  a_r9_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);
  a_r6_no_zr_write: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en_o |-> (wb_addr_o != 5'd31));
  a_r7_req_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    tmem_req_o |-> (busy_o && !done_o));
endmodule

bind tagld_unit tagld_chk i_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .tmem_req_o(tmem_req_o),
  .busy_o(busy_o), .done_o(done_o), .undef_o(undef_o), .spfault_o(spfault_o),
  .wb_en_o(wb_en_o), .wb_addr_o(wb_addr_o)
);

// File: tb/test_tagld_unit.sv
`timescale 1ns/1ps
module test_tagld_unit;
  localparam int AW = 8;

  logic        clk, rst_n, start_i, feat_en_i, tmem_vld_i;
  logic [31:0] insn_i;
  logic [63:0] sp_i, rf_data_a_i, rf_data_b_i, wb_data_o;
  logic [4:0]  rf_addr_a_o, rf_addr_b_o, wb_addr_o;
  logic [AW-1:0] tmem_addr_o;
  logic [3:0]  tmem_tag_i;
  logic        tmem_req_o, busy_o, done_o, undef_o, spfault_o, wb_en_o;
  logic [63:0] regs [32];
  int checks = 0, errors = 0;

  tagld_unit #(.AW(AW)) i_tagld_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .insn_i(insn_i),
    .feat_en_i(feat_en_i), .sp_i(sp_i),
    .rf_addr_a_o(rf_addr_a_o), .rf_data_a_i(rf_data_a_i),
    .rf_addr_b_o(rf_addr_b_o), .rf_data_b_i(rf_data_b_i),
    .tmem_req_o(tmem_req_o), .tmem_addr_o(tmem_addr_o),
    .tmem_vld_i(tmem_vld_i), .tmem_tag_i(tmem_tag_i),
    .busy_o(busy_o), .done_o(done_o), .undef_o(undef_o), .spfault_o(spfault_o),
    .wb_en_o(wb_en_o), .wb_addr_o(wb_addr_o), .wb_data_o(wb_data_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  assign rf_data_a_i = regs[rf_addr_a_o];
  assign rf_data_b_i = regs[rf_addr_b_o];

  function automatic logic [3:0] mem_tag(input int idx);
    return 4'((idx * 7 + 3) % 16);
  endfunction

  function automatic logic [31:0] enc(input logic [8:0] imm, input logic [4:0] rn,
                                      input logic [4:0] rt);
    return {8'hD9, 2'b01, 1'b1, imm, 2'b00, rn, rt};
  endfunction

  task automatic chk(input string rq, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] w, input logic feat, input logic [63:0] sp,
                     input int lat, input bit stray, input bit poke);
    logic [4:0] rn, rt;
    logic [8:0] imm;
    bit hit, und, flt;
    longint base, eaddr;
    int idx, exp_done, exp_req;
    logic [63:0] exp_wb;
    logic [3:0] tg;
    rn  = w[9:5];
    rt  = w[4:0];
    imm = w[20:12];
    hit = (w[31:24] == 8'hD9) && (w[23:22] == 2'b01) && w[21] && (w[11:10] == 2'b00);
    und = !(hit && feat);
    base = (rn == 5'd31) ? longint'(sp) : longint'(regs[rn]);
    flt = !und && (rn == 5'd31) && (sp % 16 != 0);
    eaddr = (base + longint'($signed(imm)) * 16) & ~longint'(15);
    idx = int'((eaddr >> 4) & ((1 << AW) - 1));
    tg = mem_tag(idx);
    exp_wb = regs[rt];
    exp_wb[59:56] = tg;
    exp_done = (und || flt) ? 1 : 2 + lat;
    exp_req  = (und || flt) ? -1 : 1;

    @(negedge clk);
    insn_i = w; feat_en_i = feat; sp_i = sp; start_i = 1'b1;
    @(posedge clk);
    for (int it = 0; it <= exp_done + 1; it++) begin
      @(negedge clk);
      start_i = 1'b0;
      tmem_vld_i = 1'b0;
      chk("R8", "done", 64'(done_o), 64'(it == exp_done));
      chk("R7", "req", 64'(tmem_req_o), 64'(it == exp_req));
      chk("R9", "busy", 64'(busy_o), 64'(it <= exp_done));
      if (it == exp_req) chk("R3", "tag addr", 64'(tmem_addr_o), 64'(idx));
      if (it == exp_done) begin
        chk(und ? "R1" : "R2", "undef", 64'(undef_o), 64'(und));
        chk("R4", "spfault", 64'(spfault_o), 64'(flt));
        chk("R6", "wb_en", 64'(wb_en_o), 64'(!und && !flt && rt != 5'd31));
        if (!und && !flt && rt != 5'd31) begin
          chk("R5", "wb_addr", 64'(wb_addr_o), 64'(rt));
          chk("R5", "wb_data", wb_data_o, exp_wb);
        end
      end
      if (stray && it == 0) begin tmem_vld_i = 1'b1; tmem_tag_i = ~tg; end
      if (poke && it == 1) begin start_i = 1'b1; insn_i = enc(9'h0F0, 5'd2, 5'd9); end
      if (!und && !flt && it == 1 + lat) begin tmem_vld_i = 1'b1; tmem_tag_i = tg; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) regs[i] = {32'hA5A5_0000 + 32'(i), 32'h1234_5670 + 32'(i * 3)};
    regs[3] = 64'h1000_0000_0000_1237;
    rst_n = 1'b0; start_i = 1'b0; insn_i = '0; feat_en_i = 1'b1; sp_i = '0;
    tmem_vld_i = 1'b0; tmem_tag_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk("R10", "busy", 64'(busy_o), 0);
    chk("R10", "done", 64'(done_o), 0);
    chk("R10", "req", 64'(tmem_req_o), 0);
    chk("R10", "flags", 64'({wb_en_o, undef_o, spfault_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "idle after release", 64'(busy_o), 0);

    run(enc(9'd5, 5'd3, 5'd5), 1'b1, 64'h0, 1, 0, 0);                    // R3 R5 basic
    run(enc(9'h100, 5'd4, 5'd7), 1'b1, 64'h0, 4, 0, 0);                  // R3 min imm
    run(enc(9'h0FF, 5'd6, 5'd1), 1'b1, 64'h0, 2, 0, 0);                  // R3 max imm
    run(enc(9'h1FF, 5'd31, 5'd8), 1'b1, 64'h8000_0000_0000_0040, 3, 0, 0); // R4 aligned sp
    run(enc(9'd2, 5'd31, 5'd8), 1'b1, 64'h0000_0000_0000_0048, 1, 0, 0);   // R4 misaligned
    run(enc(9'd2, 5'd3, 5'd8), 1'b0, 64'h0, 1, 0, 0);                    // R2 feature off
    run(enc(9'd2, 5'd3, 5'd8) ^ 32'h00C0_0000, 1'b1, 64'h0, 1, 0, 0);    // R1 bad opc
    run(enc(9'd2, 5'd3, 5'd8) | 32'h0000_0400, 1'b1, 64'h0, 1, 0, 0);    // R1 bad op2
    run(enc(9'd2, 5'd3, 5'd8) ^ 32'h0100_0000, 1'b1, 64'h0, 1, 0, 0);    // R1 bad top byte
    run(enc(9'd9, 5'd3, 5'd31), 1'b1, 64'h0, 2, 0, 0);                   // R6 zero register
    run(enc(9'h1F0, 5'd10, 5'd11), 1'b1, 64'h0, 5, 1, 1);                // R7 R9 stray vld, poke
    regs[12] = 64'h0;
    run(enc(9'h1FF, 5'd12, 5'd13), 1'b1, 64'h0, 1, 0, 0);                // R3 wrap below zero

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule